// File: doc/BRIEF.md
# Dual-Clock Eye-Scan Phase Controller

This block is the digital loop of a clock-and-data-recovery scheme in which two sampling clocks take their phases from a single delay line. The line spans two unit intervals and offers 32 taps, 16 per unit interval. At any moment one clock, the data clock, sits at the eye centre and its samples form the recovered bit stream. The other clock, the search clock, walks across every tap. At each tap the controller counts how often the search sample disagrees with the data sample of the same bit. A tap whose count stays at or below a programmable limit is marked open.

After a full walk the controller takes the centre of the longest run of open taps and parks the search clock there. After one settling bit it swaps the two roles on a bit boundary. The old data clock then starts the next walk. Repeating this without end lets the phase follow any drift, even though the line is only two unit intervals long, and needs no phase-locked or delay-locked loop. Each clock is placed only by comparisons made with that same clock, so a fixed skew between the two clock paths does not bias alignment. A tap in the upper half of the line samples one bit later, so both the comparison and the output are re-aligned by one bit. No bit is lost or repeated when the data clock crosses between halves.

Top module: `eyescan_phase_ctrl`

## Requirements
- R1: During and after reset clock A holds the data role (`role_b_data`=0) at tap 8, clock B is at tap 0, `locked`=0 and `rx_valid`=0.
- R2: A tap is "upper" when its index is 16 or more (index bit 4 set) and then samples the bit one period older than a lower tap does. After each bit edge, `rx_bit` holds the data clock's sample of that bit when the data tap is upper, and its sample of the previous bit when it is lower. `rx_valid` marks the cycle after a bit edge, and `rx_bit` is held otherwise.
- R3: The search clock visits taps 0 to 31 in ascending order. It stays 2^N+1 bit periods on each tap, and the first of those periods is not compared. N is `win_log2` clamped to the range 6 to 12. With a bit every cycle, two successive role swaps are 32*(2^N+1)+3 bits apart.
- R4: The search sample is compared with the data clock's sample of the same bit after the one-bit upper/lower re-alignment. A tap is open when its disagreement count is at or below `open_thr`.
- R5: The chosen tap is the centre of the longest run of adjacent open taps, with index 31 not adjacent to 0. For an even run it is the lower of the two middle taps, and among runs of equal length the lowest-indexed run wins.
- R6: When a tap is open, the search clock moves to the chosen tap and stays there for one full bit. On the next bit edge the roles swap. The new data clock keeps its tap, the new search clock restarts at tap 0, and `locked` is 1.
- R7: When no tap is open, the roles stay, the data tap stays, `locked` goes to 0, and a new walk begins.
- R8: Across every swap, including one where the data tap changes between the lower and upper halves, the recovered stream has no missing or repeated bit.
- R9: The data clock's tap changes only at a swap, and the role flag changes only on a cycle with `bit_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | One bit period's samples are present |
| smp_a | input | 1 | Sample taken by clock A |
| smp_b | input | 1 | Sample taken by clock B |
| win_log2 | input | 4 | Log2 of the per-tap observation window |
| open_thr | input | 13 | Highest disagreement count of an open tap |
| tap_a | output | 5 | Tap index for clock A |
| tap_b | output | 5 | Tap index for clock B |
| role_b_data | output | 1 | 1 when clock B is the data clock |
| rx_bit | output | 1 | Recovered bit |
| rx_valid | output | 1 | `rx_bit` carries a new bit |
| locked | output | 1 | Last walk found an open tap |

## Verification
The assertions check on every cycle that the role flag moves only on bit edges and that the data tap stays fixed between swaps. They also check that the clock taking the data role keeps the tap it was parked on, that every swap happens with `locked` high, and that `rx_bit` holds while no bit arrives. The choice of tap, the walk order and length, the clamping of the window, the no-open fallback and the gap-free recovered stream across lower/upper crossings depend on an eye model. Only the bench's scenarios can show them. Those scenarios include a steady drift of more than one unit interval, an even-width eye and a scan that is pure noise.

// File: rtl/eyescan_pkg.sv
package eyescan_pkg;
    typedef enum logic [1:0] {
        ST_SWEEP  = 2'd0,
        ST_PICK   = 2'd1,
        ST_SETTLE = 2'd2,
        ST_SWAP   = 2'd3
    } scan_st_e;
endpackage

// File: rtl/eyescan_align.sv
// Lines up search and data samples of the same bit and produces the retimed output bit.
module eyescan_align (
    input  logic d_now,
    input  logic d_prev,
    input  logic s_now,
    input  logic s_prev,
    input  logic d_hi,
    input  logic s_hi,
    output logic miss,
    output logic rx_next
);
    always_comb begin
        unique case ({s_hi, d_hi})
            2'b10:   miss = s_now ^ d_prev;   // search sees the older bit
            2'b01:   miss = s_prev ^ d_now;   // data sees the older bit
            default: miss = s_now ^ d_now;
        endcase
        rx_next = d_hi ? d_now : d_prev;
    end
endmodule

// File: rtl/eyescan_best.sv
// Finds the centre of the longest run of open taps; the earliest run wins ties.
module eyescan_best #(
    parameter int TAPS  = 32,
    parameter int TAP_W = 5
) (
    input  logic [TAPS-1:0]  open_map,
    output logic [TAP_W-1:0] best,
    output logic             any_open
);
    logic [TAP_W:0]   run_len;
    logic [TAP_W:0]   best_len;
    logic [TAP_W:0]   half_len;
    logic [TAP_W-1:0] run_st;
    logic [TAP_W-1:0] best_st;

    always_comb begin
        run_len  = '0;
        best_len = '0;
        run_st   = '0;
        best_st  = '0;
        for (int i = 0; i < TAPS; i++) begin
            if (open_map[i]) begin
                if (run_len == '0) run_st = TAP_W'(i);
                run_len = run_len + 1'b1;
                if (run_len > best_len) begin
                    best_len = run_len;
                    best_st  = run_st;
                end
            end else begin
                run_len = '0;
            end
        end
        half_len = (best_len - 1'b1) >> 1;
        best     = best_st + half_len[TAP_W-1:0];
        any_open = |open_map;
    end
endmodule

// File: rtl/eyescan_phase_ctrl.sv
module eyescan_phase_ctrl #(
    parameter int TAPS_PER_UI  = 16,
    parameter int MIN_WIN_LOG2 = 6,
    parameter int MAX_WIN_LOG2 = 12,
    parameter int RST_TAP      = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bit_valid,
    input  logic                              smp_a,
    input  logic                              smp_b,
    input  logic [3:0]                        win_log2,
    input  logic [MAX_WIN_LOG2:0]             open_thr,
    output logic [$clog2(2*TAPS_PER_UI)-1:0]  tap_a,
    output logic [$clog2(2*TAPS_PER_UI)-1:0]  tap_b,
    output logic                              role_b_data,
    output logic                              rx_bit,
    output logic                              rx_valid,
    output logic                              locked
);
    import eyescan_pkg::*;

    localparam int TAPS  = 2 * TAPS_PER_UI;
    localparam int TAP_W = $clog2(TAPS);
    localparam int CNT_W = MAX_WIN_LOG2 + 1;
    localparam logic [TAP_W-1:0] UI_TAP   = TAP_W'(TAPS_PER_UI);
    localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(TAPS - 1);
    localparam logic [3:0]       MIN_W    = 4'(MIN_WIN_LOG2);
    localparam logic [3:0]       MAX_W    = 4'(MAX_WIN_LOG2);

    typedef struct packed {
        scan_st_e         st;
        logic [TAP_W-1:0] idx;
        logic [TAP_W-1:0] dtap;
        logic [TAP_W-1:0] best;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] mm;
        logic [TAPS-1:0]  omap;
        logic             role;
        logic             locked;
        logic             prev_a;
        logic             prev_b;
        logic             rx;
        logic             rxv;
    } ctl_t;

    ctl_t q, d;

    logic [3:0]       n_eff;
    logic [CNT_W-1:0] win_last;
    logic [CNT_W-1:0] mm_new;
    logic [TAP_W-1:0] stap;
    logic [TAP_W-1:0] pick_tap;
    logic             pick_ok;
    logic             d_now, d_prev, s_now, s_prev;
    logic             miss, rx_next;

    assign n_eff    = (win_log2 < MIN_W) ? MIN_W : ((win_log2 > MAX_W) ? MAX_W : win_log2);
    assign win_last = CNT_W'(1) << n_eff;
    assign stap     = (q.st == ST_SWEEP || q.st == ST_PICK) ? q.idx : q.best;

    assign d_now  = q.role ? smp_b    : smp_a;
    assign s_now  = q.role ? smp_a    : smp_b;
    assign d_prev = q.role ? q.prev_b : q.prev_a;
    assign s_prev = q.role ? q.prev_a : q.prev_b;

    eyescan_align i_align (
        .d_now   (d_now),
        .d_prev  (d_prev),
        .s_now   (s_now),
        .s_prev  (s_prev),
        .d_hi    (q.dtap >= UI_TAP),
        .s_hi    (stap >= UI_TAP),
        .miss    (miss),
        .rx_next (rx_next)
    );

    eyescan_best #(.TAPS(TAPS), .TAP_W(TAP_W)) i_best (
        .open_map (q.omap),
        .best     (pick_tap),
        .any_open (pick_ok)
    );

    assign mm_new = q.mm + CNT_W'((q.cnt != '0) && miss);

    always_comb begin
        d     = q;
        d.rxv = bit_valid;
        if (bit_valid) begin
            d.prev_a = smp_a;
            d.prev_b = smp_b;
            d.rx     = rx_next;
        end
        unique case (q.st)
            ST_SWEEP: begin
                if (bit_valid) begin
                    if (q.cnt == win_last) begin
                        d.omap[q.idx] = (mm_new <= open_thr);
                        d.cnt = '0;
                        d.mm  = '0;
                        if (q.idx == LAST_TAP) d.st  = ST_PICK;
                        else                   d.idx = q.idx + 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                        d.mm  = mm_new;
                    end
                end
            end
            ST_PICK: begin
                if (pick_ok) begin
                    d.best   = pick_tap;
                    d.locked = 1'b1;
                    d.st     = ST_SETTLE;
                end else begin
                    d.locked = 1'b0;
                    d.idx    = '0;
                    d.st     = ST_SWEEP;
                end
            end
            ST_SETTLE: begin
                if (bit_valid) d.st = ST_SWAP;
            end
            ST_SWAP: begin
                if (bit_valid) begin
                    d.role = ~q.role;
                    d.dtap = q.best;
                    d.idx  = '0;
                    d.cnt  = '0;
                    d.mm   = '0;
                    d.st   = ST_SWEEP;
                end
            end
            default: d.st = ST_SWEEP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_SWEEP;
            q.dtap <= TAP_W'(RST_TAP);
        end else begin
            q <= d;
        end
    end

    assign tap_a       = q.role ? stap   : q.dtap;
    assign tap_b       = q.role ? q.dtap : stap;
    assign role_b_data = q.role;
    assign rx_bit      = q.rx;
    assign rx_valid    = q.rxv;
    assign locked      = q.locked;
endmodule

// File: rtl/eyescan_phase_ctrl_chk.sv
module eyescan_phase_ctrl_chk #(
    parameter int TAP_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_valid,
    input logic [TAP_W-1:0] tap_a,
    input logic [TAP_W-1:0] tap_b,
    input logic             role_b_data,
    input logic             rx_bit,
    input logic             rx_valid,
    input logic             locked
);
    assert_rx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_bit));

    assert_role_on_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |=> $stable(role_b_data));

    assert_data_tap_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(role_b_data) |-> (role_b_data ? $stable(tap_b) : $stable(tap_a)));

    assert_b_keeps_tap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(role_b_data) |-> $stable(tap_b));

    assert_a_keeps_tap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(role_b_data) |-> $stable(tap_a));

    assert_swap_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(role_b_data) |-> locked);
endmodule

bind eyescan_phase_ctrl eyescan_phase_ctrl_chk #(.TAP_W(TAP_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_valid   (bit_valid),
    .tap_a       (tap_a),
    .tap_b       (tap_b),
    .role_b_data (role_b_data),
    .rx_bit      (rx_bit),
    .rx_valid    (rx_valid),
    .locked      (locked)
);

// File: tb/test_eyescan_phase_ctrl.sv
module test_eyescan_phase_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_valid = 1'b0;
    logic        smp_a = 1'b0;
    logic        smp_b = 1'b0;
    logic [3:0]  win_log2 = 4'd6;
    logic [12:0] open_thr = 13'd4;
    logic [4:0]  tap_a, tap_b;
    logic        role_b_data, rx_bit, rx_valid, locked;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // environment state
    int eye_ctr = 8;
    int lo_w = 3;
    int hi_w = 3;
    bit noise = 0;
    int quiet = 0;
    bit hist [4];
    int nb = 0;
    int flips = 0;
    int flip_nb = 0;
    int prev_flip_nb = 0;
    bit last_role = 0;
    bit sweep_chk = 0;
    int sweep_w1 = 65;

    always #4 clk = ~clk;

    eyescan_phase_ctrl i_eyescan_phase_ctrl (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .smp_a(smp_a), .smp_b(smp_b),
        .win_log2(win_log2), .open_thr(open_thr), .tap_a(tap_a), .tap_b(tap_b),
        .role_b_data(role_b_data), .rx_bit(rx_bit), .rx_valid(rx_valid), .locked(locked)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit is_open(input int t);
        int off;
        off = (((t - eye_ctr) % 16) + 16) % 16;
        if (off > 8) off = off - 16;
        return (off >= -lo_w) && (off <= hi_w);
    endfunction

    function automatic int exp_best();
        int run, st, blen, bst;
        run = 0; st = 0; blen = 0; bst = 0;
        for (int t = 0; t < 32; t++) begin
            if (is_open(t)) begin
                if (run == 0) st = t;
                run++;
                if (run > blen) begin blen = run; bst = st; end
            end else run = 0;
        end
        return bst + (blen - 1) / 2;
    endfunction

    function automatic bit sample(input int t, input int k);
        if (noise || !is_open(t)) return 1'($urandom % 2);
        return (t >= 16) ? hist[(k + 3) & 3] : hist[k & 3];
    endfunction

    function automatic int dtap();
        return role_b_data ? int'(tap_b) : int'(tap_a);
    endfunction

    function automatic int stap();
        return role_b_data ? int'(tap_a) : int'(tap_b);
    endfunction

    task automatic step(input bit valid);
        int since;
        @(negedge clk);
        if (rx_valid && nb >= 3 && !noise && quiet == 0)
            chk(rx_bit == hist[(nb + 2) & 3], "R2/R8 recovered bit", rx_bit, hist[(nb + 2) & 3]);
        if (role_b_data != last_role) begin
            last_role    = role_b_data;
            prev_flip_nb = flip_nb;
            flip_nb      = nb;
            flips++;
        end
        since = nb - flip_nb;
        if (sweep_chk && since < 32 * sweep_w1 && (since % sweep_w1) == 7)
            chk(stap() == since / sweep_w1, "R3 sweep tap", stap(), since / sweep_w1);
        bit_valid = valid;
        if (valid) begin
            hist[nb & 3] = 1'($urandom % 2);
            smp_a = sample(int'(tap_a), nb);
            smp_b = sample(int'(tap_b), nb);
            nb++;
            if (quiet > 0) quiet--;
        end
    endtask

    task automatic run_scan(input int n_eff, input bit gaps, input bit chk_tap, input bit chk_len);
        int exp, f0, guard;
        exp = exp_best();
        f0 = flips;
        guard = 0;
        sweep_w1  = (1 << n_eff) + 1;
        sweep_chk = !gaps && chk_len;
        while (flips == f0 && guard < 12000) begin
            step(gaps ? ($urandom % 4 != 0) : 1'b1);
            guard++;
        end
        sweep_chk = 0;
        chk(flips == f0 + 1, "R6 swap occurred", flips - f0, 1);
        chk(locked == 1'b1, "R6 locked after swap", locked, 1);
        chk(stap() == 0, "R6 new search at tap 0", stap(), 0);
        if (chk_tap)
            chk(dtap() == exp, "R5 chosen data tap", dtap(), exp);
        if (chk_len)
            chk(flip_nb - prev_flip_nb == 32 * sweep_w1 + 3, "R3 scan length",
                flip_nb - prev_flip_nb, 32 * sweep_w1 + 3);
    endtask

    initial begin
        repeat (199000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int saved_d, saved_role;
        for (int i = 0; i < 4; i++) hist[i] = 1'b0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(tap_a == 5'd8, "R1 tap_a reset", tap_a, 8);
        chk(tap_b == 5'd0, "R1 tap_b reset", tap_b, 0);
        chk(role_b_data == 1'b0, "R1 role reset", role_b_data, 0);
        chk(locked == 1'b0, "R1 locked reset", locked, 0);
        chk(rx_valid == 1'b0, "R1 rx_valid reset", rx_valid, 0);
        rst_n = 1'b1;

        // first scan from reset, eye centred on tap 8
        run_scan(6, 1'b0, 1'b1, 1'b0);
        chk(role_b_data == 1'b1, "R6 role toggled", role_b_data, 1);

        // random small drifts, some with bit gaps
        for (int s = 0; s < 6; s++) begin
            eye_ctr = (eye_ctr + int'($urandom_range(0, 4)) - 2 + 16) % 16;
            run_scan(6, s[0], 1'b1, !s[0]);
        end

        // steady drift over more than one unit interval (R8 crossings)
        for (int s = 0; s < 12; s++) begin
            eye_ctr = (eye_ctr + 2) % 16;
            run_scan(6, 1'b0, 1'b1, 1'b1);
        end

        // wider window, then clamped small window (R3)
        win_log2 = 4'd7;
        run_scan(7, 1'b0, 1'b1, 1'b1);
        win_log2 = 4'd3;
        run_scan(6, 1'b0, 1'b1, 1'b1);

        // even-width eye: lower middle tap (R5)
        lo_w = 3; hi_w = 2;
        run_scan(6, 1'b0, 1'b1, 1'b1);

        // threshold zero: open taps with no disagreement still open (R4)
        open_thr = 13'd0;
        run_scan(6, 1'b1, 1'b1, 1'b0);
        open_thr = 13'd4;

        // pure noise: nothing open (R7)
        saved_d = dtap();
        saved_role = int'(role_b_data);
        noise = 1;
        repeat (32 * 65 + 3) step(1'b1);
        chk(locked == 1'b0, "R7 locked cleared", locked, 0);
        chk(int'(role_b_data) == saved_role, "R7 role kept", role_b_data, saved_role);
        chk(dtap() == saved_d, "R7 data tap kept", dtap(), saved_d);
        noise = 0;
        quiet = 4;
        run_scan(6, 1'b0, 1'b1, 1'b0);

        repeat (20) step(1'b1);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule